// File: doc/BRIEF.md
# CPU Bus Protocol Bridge

The bridge connects a processor whose address and data share one 32-bit set of lines to two kinds of target. The first is an on-chip peripheral bus with a request, grant and acknowledge handshake. The second is an external USB controller device that is driven with an active-low chip select and active-low read and write strobes. On the address phase the bridge captures the upper address bits into a holding register. The two lowest word-address bits come from dedicated processor pins. From the captured address the bridge picks the target.

On the data phase the processor's cycle-in-progress signal, read and write strobes and byte enables are turned into the chosen target's signalling. Write data is registered and driven out. Read data is registered when the target finishes and returned to the processor together with a single-clock active-low acknowledge. A new address phase may overlap the acknowledge clock of the previous cycle, so transfers can run back to back.

Top module: `cpu_bus_bridge`

## Requirements
- R1: Out of reset, `cpu_ack_no`, `ib_rd_no`, `ib_wr_no` (all four), `usb_cs_no`, `usb_rd_no` and `usb_wr_no` are high, and `ib_req_o` and `cpu_rdata_oe_o` are low.
- R2: `tgt_addr_o[31:4]` equals `cpu_ad_i[31:4]` as sampled on the last rising clock edge at which `cpu_ale_i` was high while the bridge was idle or acknowledging. An address strobe that arrives at any other point of a cycle leaves the address unchanged.
- R3: `tgt_addr_o[3:2]` follows `cpu_addr_lo_i[1:0]`. Bits [3:2] of the shared bus are never used.
- R4: A cycle goes to the USB device when captured address bits [31:28] equal `USB_SEL` (default 4'hB). Any other value sends it to the internal bus.
- R5: For an internal cycle, `ib_req_o` is held from one clock after the data phase is seen until the acknowledge clock. The read or write strobes start only after `ib_gnt_i` has been sampled high, and they stay asserted until the clock edge at which `ib_ack_i` is sampled high. With the target raising its acknowledge d clocks after the strobe starts, the strobe lasts max(d,1)+1 clocks.
- R6: An internal write drives `ib_wr_no[i]` low exactly for the lanes whose `cpu_be_ni[i]` was low, and keeps `ib_rd_no` high. An internal read drives only `ib_rd_no` low.
- R7: A USB cycle holds `usb_cs_no` low for one clock before the strobe. It then drives `usb_rd_no` or `usb_wr_no` low for exactly `STROBE_CYCLES` clocks (default 3), and keeps `usb_cs_no` low for one clock after the strobe ends.
- R8: `cpu_ack_no` is low for exactly one clock per cycle. On reads, `cpu_rdata_o` then carries the target data sampled when the target acknowledged (internal) or on the last strobe clock (USB), and `cpu_rdata_oe_o` is high. On writes, `cpu_rdata_oe_o` stays low.
- R9: `tgt_wdata_o` carries the value of `cpu_ad_i` from the clock at which the write data phase was first seen.
- R10: An address strobe sampled in the acknowledge clock starts the next cycle with no idle clock between them.
- R11: `ib_req_o` high and `usb_cs_no` low never occur in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_ad_i | input | 32 | Shared address/data lines from the processor |
| cpu_ale_i | input | 1 | Address phase strobe |
| cpu_addr_lo_i | input | 2 | Word address bits [3:2] from dedicated pins |
| cpu_cyc_ni | input | 1 | Cycle in progress, active low |
| cpu_rd_ni | input | 1 | Read strobe, active low |
| cpu_wr_ni | input | 1 | Write strobe, active low |
| cpu_be_ni | input | 4 | Byte enables, active low |
| cpu_ack_no | output | 1 | Cycle acknowledge to processor, active low |
| cpu_rdata_o | output | 32 | Read data to processor |
| cpu_rdata_oe_o | output | 1 | Read data valid / bus drive enable |
| tgt_addr_o | output | 30 | Word address to both targets, bits [31:2] |
| tgt_wdata_o | output | 32 | Write data to both targets |
| tgt_rdata_i | input | 32 | Read data from the selected target |
| ib_req_o | output | 1 | Internal bus request |
| ib_gnt_i | input | 1 | Internal bus grant |
| ib_ack_i | input | 1 | Internal bus target acknowledge |
| ib_rd_no | output | 1 | Internal bus read strobe, active low |
| ib_wr_no | output | 4 | Internal bus per-lane write strobes, active low |
| usb_cs_no | output | 1 | USB device chip select, active low |
| usb_rd_no | output | 1 | USB device read strobe, active low |
| usb_wr_no | output | 1 | USB device write strobe, active low |

## Verification
Two things can happen in the same clock: the acknowledge of one cycle and the address capture of the next. The bench provokes this by raising the address strobe in the very clock in which it sees the acknowledge low, for a mixed run of internal and USB transfers. It then judges the next transfer by the address and strobes seen at the target and by the read data returned. A second overlap is an address strobe pulsed during the data phase of a read while the target is being addressed. That case is judged by the address held at the target's strobe and by the read data, which is derived from that address.

// File: rtl/cbb_pkg.sv
package cbb_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_REQ, ST_WAIT_GNT, ST_XFER, ST_WAIT_ACK,
    ST_USB_SETUP, ST_USB_STROBE, ST_USB_HOLD, ST_DONE
  } bus_state_e;
endpackage

// File: rtl/cbb_addr_latch.sv
module cbb_addr_latch #(
  parameter int HI_W  = 28,
  parameter int SEL_W = 4,
  parameter logic [SEL_W-1:0] USB_SEL = 4'hB
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            lat_en_i,
  input  logic [HI_W-1:0] ad_hi_i,
  output logic [HI_W-1:0] addr_hi_o,
  output logic            is_usb_o
);
  logic [HI_W-1:0] addr_hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       addr_hi_q <= '0;
    else if (lat_en_i) addr_hi_q <= ad_hi_i;
  end

  assign addr_hi_o = addr_hi_q;
  assign is_usb_o  = (addr_hi_q[HI_W-1 -: SEL_W] == USB_SEL);
endmodule

// File: rtl/cbb_seq.sv
module cbb_seq
  import cbb_pkg::*;
#(
  parameter int STROBE_CYCLES = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ale_i,
  input  logic cyc_ni,
  input  logic rd_ni,
  input  logic wr_ni,
  input  logic is_usb_i,
  input  logic gnt_i,
  input  logic ack_i,
  output logic lat_en_o,
  output logic cap_o,
  output logic rd_cap_o,
  output logic ib_req_o,
  output logic ib_rd_no,
  output logic ib_wr_en_o,
  output logic usb_cs_no,
  output logic usb_rd_no,
  output logic usb_wr_no,
  output logic cpu_ack_no,
  output logic rdata_oe_o
);
  localparam int CNT_W = $clog2(STROBE_CYCLES + 1);

  bus_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q;
  logic is_wr_q;
  logic go, stb_last;

  assign go       = !cyc_ni && (!rd_ni || !wr_ni);
  assign stb_last = (cnt_q == CNT_W'(STROBE_CYCLES - 1));
  assign lat_en_o = ale_i && (state_q == ST_IDLE || state_q == ST_DONE);
  assign cap_o    = (state_q == ST_ADDR) && go;
  assign rd_cap_o = ((state_q == ST_WAIT_ACK) && ack_i) ||
                    ((state_q == ST_USB_STROBE) && stb_last);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:       if (ale_i) state_d = ST_ADDR;
      ST_ADDR:       if (go) state_d = is_usb_i ? ST_USB_SETUP : ST_REQ;
      ST_REQ:        state_d = ST_WAIT_GNT;
      ST_WAIT_GNT:   if (gnt_i) state_d = ST_XFER;
      ST_XFER:       state_d = ST_WAIT_ACK;
      ST_WAIT_ACK:   if (ack_i) state_d = ST_DONE;
      ST_USB_SETUP:  state_d = ST_USB_STROBE;
      ST_USB_STROBE: if (stb_last) state_d = ST_USB_HOLD;
      ST_USB_HOLD:   state_d = ST_DONE;
      ST_DONE:       state_d = ale_i ? ST_ADDR : ST_IDLE;
      default:       state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      is_wr_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (cap_o) is_wr_q <= !wr_ni;
      if (state_q == ST_USB_SETUP)       cnt_q <= '0;
      else if (state_q == ST_USB_STROBE) cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    ib_req_o   = 1'b0;
    ib_rd_no   = 1'b1;
    ib_wr_en_o = 1'b0;
    usb_cs_no  = 1'b1;
    usb_rd_no  = 1'b1;
    usb_wr_no  = 1'b1;
    cpu_ack_no = 1'b1;
    rdata_oe_o = 1'b0;
    case (state_q)
      ST_REQ, ST_WAIT_GNT: ib_req_o = 1'b1;
      ST_XFER, ST_WAIT_ACK: begin
        ib_req_o   = 1'b1;
        ib_rd_no   = is_wr_q;
        ib_wr_en_o = is_wr_q;
      end
      ST_USB_SETUP, ST_USB_HOLD: usb_cs_no = 1'b0;
      ST_USB_STROBE: begin
        usb_cs_no = 1'b0;
        usb_rd_no = is_wr_q;
        usb_wr_no = !is_wr_q;
      end
      ST_DONE: begin
        cpu_ack_no = 1'b0;
        rdata_oe_o = !is_wr_q;
      end
      default: ;
    endcase
  end

  // R8
  ack_one_clk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_ack_no |=> cpu_ack_no);
  // R11
  excl_path_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ib_req_o && !usb_cs_no));
  // R7
  usb_stb_in_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!usb_rd_no || !usb_wr_no) |-> !usb_cs_no);
  // R7
  usb_stb_setup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(usb_cs_no) |-> (usb_rd_no && usb_wr_no));
  // R5
  ib_gnt_before_stb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ib_req_o && !gnt_i && ib_rd_no && !ib_wr_en_o) |=> (ib_rd_no && !ib_wr_en_o));
endmodule

// File: rtl/cbb_datapath.sv
module cbb_datapath #(
  parameter int DATA_W = 32,
  parameter int BE_W   = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic              rd_cap_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] ad_i,
  input  logic [BE_W-1:0]   be_ni,
  input  logic [DATA_W-1:0] tgt_rdata_i,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [BE_W-1:0]   wr_no
);
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic [BE_W-1:0]   be_nq;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wdata_q <= '0;
      rdata_q <= '0;
      be_nq   <= '1;
    end else begin
      if (cap_i) begin
        wdata_q <= ad_i;
        be_nq   <= be_ni;
      end
      if (rd_cap_i) rdata_q <= tgt_rdata_i;
    end
  end

  for (genvar i = 0; i < BE_W; i++) begin : g_lane
    assign wr_no[i] = !(wr_en_i && !be_nq[i]);
  end

  assign wdata_o = wdata_q;
  assign rdata_o = rdata_q;

  // R6
  lane_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_no != '1) |-> ((wr_no | be_nq) == wr_no));
endmodule

// File: rtl/cpu_bus_bridge.sv
module cpu_bus_bridge #(
  parameter int DATA_W        = 32,
  parameter int LO_W          = 2,
  parameter int SEL_W         = 4,
  parameter logic [SEL_W-1:0] USB_SEL = 4'hB,
  parameter int STROBE_CYCLES = 3,
  localparam int BE_W         = DATA_W / 8,
  localparam int HI_LSB       = LO_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] cpu_ad_i,
  input  logic              cpu_ale_i,
  input  logic [LO_W-1:0]   cpu_addr_lo_i,
  input  logic              cpu_cyc_ni,
  input  logic              cpu_rd_ni,
  input  logic              cpu_wr_ni,
  input  logic [BE_W-1:0]   cpu_be_ni,
  output logic              cpu_ack_no,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              cpu_rdata_oe_o,
  output logic [DATA_W-1:2] tgt_addr_o,
  output logic [DATA_W-1:0] tgt_wdata_o,
  input  logic [DATA_W-1:0] tgt_rdata_i,
  output logic              ib_req_o,
  input  logic              ib_gnt_i,
  input  logic              ib_ack_i,
  output logic              ib_rd_no,
  output logic [BE_W-1:0]   ib_wr_no,
  output logic              usb_cs_no,
  output logic              usb_rd_no,
  output logic              usb_wr_no
);
  localparam int HI_W = DATA_W - HI_LSB;

  logic            lat_en, cap, rd_cap, wr_en, is_usb;
  logic [HI_W-1:0] addr_hi;

  cbb_addr_latch #(.HI_W(HI_W), .SEL_W(SEL_W), .USB_SEL(USB_SEL)) u_latch (
    .clk_i, .rst_ni,
    .lat_en_i (lat_en),
    .ad_hi_i  (cpu_ad_i[DATA_W-1:HI_LSB]),
    .addr_hi_o(addr_hi),
    .is_usb_o (is_usb)
  );

  cbb_seq #(.STROBE_CYCLES(STROBE_CYCLES)) u_seq (
    .clk_i, .rst_ni,
    .ale_i     (cpu_ale_i),
    .cyc_ni    (cpu_cyc_ni),
    .rd_ni     (cpu_rd_ni),
    .wr_ni     (cpu_wr_ni),
    .is_usb_i  (is_usb),
    .gnt_i     (ib_gnt_i),
    .ack_i     (ib_ack_i),
    .lat_en_o  (lat_en),
    .cap_o     (cap),
    .rd_cap_o  (rd_cap),
    .ib_req_o  (ib_req_o),
    .ib_rd_no  (ib_rd_no),
    .ib_wr_en_o(wr_en),
    .usb_cs_no (usb_cs_no),
    .usb_rd_no (usb_rd_no),
    .usb_wr_no (usb_wr_no),
    .cpu_ack_no(cpu_ack_no),
    .rdata_oe_o(cpu_rdata_oe_o)
  );

  cbb_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk_i, .rst_ni,
    .cap_i      (cap),
    .rd_cap_i   (rd_cap),
    .wr_en_i    (wr_en),
    .ad_i       (cpu_ad_i),
    .be_ni      (cpu_be_ni),
    .tgt_rdata_i(tgt_rdata_i),
    .wdata_o    (tgt_wdata_o),
    .rdata_o    (cpu_rdata_o),
    .wr_no      (ib_wr_no)
  );

  assign tgt_addr_o = {addr_hi, cpu_addr_lo_i};

  logic busy;
  assign busy = ib_req_o || !usb_cs_no;

  // R2
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy)) |-> $stable(addr_hi));
  // R4
  usb_decode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !usb_cs_no |-> (addr_hi[HI_W-1 -: SEL_W] == USB_SEL));
endmodule

// File: tb/cpu_bus_bridge_test.sv
`timescale 1ns/1ps
module cpu_bus_bridge_test;
  localparam int STB = 3;
  localparam logic [3:0] SEL = 4'hB;

  typedef struct {
    logic [31:0] addr;
    logic        wr;
    logic [3:0]  be_n;
    logic [31:0] wdata;
    logic        usb;
  } tgt_item_t;
  typedef struct {
    logic        wr;
    logic [31:0] rdata;
  } cpu_item_t;

  logic clk = 0, rst_n = 0;
  logic [31:0] cpu_ad = '0;
  logic cpu_ale = 0, cyc_n = 1, rd_n = 1, wr_n = 1;
  logic [1:0] addr_lo = '0;
  logic [3:0] be_n = '1;
  logic cpu_ack_n, rdata_oe, ib_req, ib_rd_n, usb_cs_n, usb_rd_n, usb_wr_n;
  logic [31:0] cpu_rdata, tgt_wdata, tgt_rdata;
  logic [31:2] tgt_addr;
  logic [3:0] ib_wr_n;
  logic gnt = 0, ack = 0;
  int gnt_dly = 0, ack_dly = 0, gcnt = 0, acnt = 0;
  int n_chk = 0, n_fail = 0, excl_viol = 0;
  tgt_item_t tq[$];
  cpu_item_t cq[$];

  always #2.5 clk = ~clk;

  cpu_bus_bridge #(.USB_SEL(SEL), .STROBE_CYCLES(STB)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cpu_ad_i(cpu_ad), .cpu_ale_i(cpu_ale),
    .cpu_addr_lo_i(addr_lo), .cpu_cyc_ni(cyc_n), .cpu_rd_ni(rd_n), .cpu_wr_ni(wr_n),
    .cpu_be_ni(be_n), .cpu_ack_no(cpu_ack_n), .cpu_rdata_o(cpu_rdata),
    .cpu_rdata_oe_o(rdata_oe), .tgt_addr_o(tgt_addr), .tgt_wdata_o(tgt_wdata),
    .tgt_rdata_i(tgt_rdata), .ib_req_o(ib_req), .ib_gnt_i(gnt), .ib_ack_i(ack),
    .ib_rd_no(ib_rd_n), .ib_wr_no(ib_wr_n), .usb_cs_no(usb_cs_n),
    .usb_rd_no(usb_rd_n), .usb_wr_no(usb_wr_n)
  );

  function automatic logic [31:0] model_rd(logic [31:0] a, logic usb);
    return usb ? (a ^ 32'h0000_00C3) : (a ^ 32'h5A5A_A5A5);
  endfunction

  assign tgt_rdata = model_rd({tgt_addr, 2'b00}, !usb_cs_n);

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // target models
  always @(negedge clk) begin
    if (!ib_req) begin gnt <= 0; gcnt <= 0; end
    else if (gcnt == gnt_dly) gnt <= 1;
    else gcnt <= gcnt + 1;
    if (ib_rd_n && &ib_wr_n) begin ack <= 0; acnt <= 0; end
    else if (acnt == ack_dly) ack <= 1;
    else acnt <= acnt + 1;
  end

  // target-side monitor
  logic ib_prev = 0, usb_prev = 0, cs_prev = 1, ack_prev = 1;
  int ib_w = 0, usb_w = 0, ib_exp_w = 0;
  always @(negedge clk) begin
    logic ib_act, usb_act;
    ib_act  = !ib_rd_n || (ib_wr_n != 4'hF);
    usb_act = !usb_rd_n || !usb_wr_n;
    if (rst_n && ib_req && !usb_cs_n) excl_viol++;
    if (ib_act && !ib_prev) begin
      tgt_item_t e;
      e = tq.pop_front();
      ib_w = 1;
      ib_exp_w = (ack_dly > 1 ? ack_dly : 1) + 1;
      check(!e.usb, "R4 internal path chosen", 0, 1);
      check(tgt_addr[31:4] == e.addr[31:4], "R2 latched address", tgt_addr[31:4], e.addr[31:4]);
      check(tgt_addr[3:2] == e.addr[3:2], "R3 low address pins", tgt_addr[3:2], e.addr[3:2]);
      check(gnt == 1'b1, "R5 strobe after grant", gnt, 1);
      if (e.wr) begin
        check(ib_wr_n == e.be_n && ib_rd_n, "R6 lane write strobes", {ib_rd_n, ib_wr_n}, {1'b1, e.be_n});
        check(tgt_wdata == e.wdata, "R9 write data", tgt_wdata, e.wdata);
      end else
        check(!ib_rd_n && ib_wr_n == 4'hF, "R6 read strobe only", {ib_rd_n, ib_wr_n}, 5'h0F);
    end else if (ib_act) ib_w++;
    if (!ib_act && ib_prev)
      check(ib_w == ib_exp_w, "R5 strobe held until ack", ib_w, ib_exp_w);
    if (usb_act && !usb_prev) begin
      tgt_item_t e;
      e = tq.pop_front();
      usb_w = 1;
      check(e.usb, "R4 usb path chosen", 0, 1);
      check(tgt_addr == e.addr[31:2], "R2 R3 usb address", tgt_addr, e.addr[31:2]);
      check(!cs_prev, "R7 chip select setup clock", cs_prev, 0);
      check(usb_rd_n == e.wr && usb_wr_n == !e.wr, "R7 usb strobe direction", {usb_rd_n, usb_wr_n}, {e.wr, !e.wr});
      if (e.wr) check(tgt_wdata == e.wdata, "R9 usb write data", tgt_wdata, e.wdata);
    end else if (usb_act) usb_w++;
    if (!usb_act && usb_prev) begin
      check(usb_w == STB, "R7 strobe width", usb_w, STB);
      check(!usb_cs_n, "R7 chip select hold clock", usb_cs_n, 0);
    end
    if (!cpu_ack_n) begin
      cpu_item_t c;
      c = cq.pop_front();
      check(ack_prev, "R8 single clock ack", ack_prev, 1);
      if (c.wr) check(!rdata_oe, "R8 no drive on write", rdata_oe, 0);
      else check(rdata_oe && cpu_rdata == c.rdata, "R8 read data", {rdata_oe, cpu_rdata}, {1'b1, c.rdata});
    end
    ib_prev = ib_act; usb_prev = usb_act; cs_prev = usb_cs_n; ack_prev = cpu_ack_n;
  end

  // driver: called at a negedge, returns at the negedge where ack is seen
  task automatic cpu_xfer(logic [31:0] a, logic wr, logic [3:0] be, logic [31:0] d, bit glitch);
    tgt_item_t t;
    cpu_item_t c;
    logic usb;
    usb = (a[31:28] == SEL);
    t.addr = a; t.wr = wr; t.be_n = be; t.wdata = d; t.usb = usb;
    c.wr = wr; c.rdata = model_rd({a[31:2], 2'b00}, usb);
    tq.push_back(t); cq.push_back(c);
    cpu_ale = 1; cpu_ad = {a[31:4], ~a[3:2], 2'b00}; addr_lo = a[3:2];
    @(negedge clk);
    cpu_ale = 0; cyc_n = 0; be_n = be;
    rd_n = wr; wr_n = !wr;
    cpu_ad = wr ? d : 32'h1234_5678;
    if (glitch) begin
      @(negedge clk); cpu_ale = 1; cpu_ad = 32'hFFFF_FFF0;
      @(negedge clk); cpu_ale = 0;
    end
    do @(negedge clk); while (cpu_ack_n);
    cyc_n = 1; rd_n = 1; wr_n = 1; be_n = '1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(cpu_ack_n && ib_rd_n && ib_wr_n == 4'hF && usb_cs_n && usb_rd_n && usb_wr_n
          && !ib_req && !rdata_oe, "R1 reset outputs",
          {cpu_ack_n, ib_rd_n, ib_wr_n, usb_cs_n, usb_rd_n, usb_wr_n, ib_req, rdata_oe}, 11'h7FC);
    rst_n = 1;
    @(negedge clk);
    cpu_xfer(32'h1000_0010, 1, 4'h0, 32'hCAFE_0001, 0);
    @(negedge clk);
    // R6 partial lanes
    cpu_xfer(32'h1000_0024, 1, 4'hA, 32'hCAFE_0002, 0);
    @(negedge clk);
    gnt_dly = 2; ack_dly = 3;
    cpu_xfer(32'h2345_678C, 0, 4'h0, 32'h0, 0);
    @(negedge clk);
    gnt_dly = 0; ack_dly = 0;
    cpu_xfer(32'hB000_0004, 1, 4'h0, 32'h0000_00A5, 0);
    @(negedge clk);
    cpu_xfer(32'hB000_0108, 0, 4'h0, 32'h0, 0);
    @(negedge clk);
    // R10 back-to-back, mixed targets
    ack_dly = 1;
    cpu_xfer(32'h3000_0040, 0, 4'h0, 32'h0, 0);
    cpu_xfer(32'hB123_4568, 0, 4'h0, 32'h0, 0);
    cpu_xfer(32'h4000_0008, 1, 4'h3, 32'h1111_2222, 0);
    cpu_xfer(32'hB000_000C, 1, 4'h0, 32'h0000_005A, 0);
    @(negedge clk);
    // R2 address strobe during data phase ignored
    cpu_xfer(32'h5555_5550, 0, 4'h0, 32'h0, 1);
    @(negedge clk);
    cpu_xfer(32'hB000_0200, 0, 4'h0, 32'h0, 1);
    @(negedge clk);
    // R4 decode boundaries
    cpu_xfer(32'hAFFF_FFFC, 0, 4'h0, 32'h0, 0);
    cpu_xfer(32'hBFFF_FFFC, 0, 4'h0, 32'h0, 0);
    cpu_xfer(32'hC000_0000, 0, 4'h0, 32'h0, 0);
    repeat (4) @(negedge clk);
    check(tq.size() == 0 && cq.size() == 0, "R8 all cycles completed", tq.size() + cq.size(), 0);
    // R11
    check(excl_viol == 0, "R11 paths exclusive", excl_viol, 0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule